// File: doc/BRIEF.md
# Packed Decimal Byte Adder with Condition Flags

This block adds two packed-decimal bytes, each holding two decimal digits, together with an incoming extend bit. It takes two full-width register values and uses only their lowest byte. The sum goes back into the lowest byte of the destination value. The upper bits of the destination pass through untouched.

Alongside the result it produces five condition flags: carry, extend, zero, negative and overflow. The result and the flags are captured in an output register one clock after a valid strobe. They then hold until the next strobe.

Digits above nine are not rejected. Each digit position is corrected by the same rule whatever its value, so every input byte gives one defined result. A software routine can add multi-byte decimal numbers by feeding the extend output back as the extend input and the zero output back as the zero input, one byte at a time. The zero flag then reports zero only if every byte of the chain was zero.

Top module: `bcd_byte_adder`

## Requirements
- R1: After a strobe, bits above bit 7 of `res_o` equal the same bits of the destination input. The source input has no effect on those bits.
- R2: Digits are processed from the least significant up. Each digit's sum is its destination digit, plus its source digit, plus the carry from the digit below. For the lowest digit that carry is `x_i`. When this sum exceeds 9, six is added to it. The low four bits become the result digit, and the bits above them carry into the next digit. Example: 0x7A + 0x78 with `x_i`=0 gives 0x58.
- R3: Carry is set exactly when the most significant digit needed the correction. Examples: 0x45 + 0x54 with `x_i`=1 gives 0x00 with carry set; 0xA2 + 0x19 with `x_i`=1 gives 0x22 with carry set.
- R4: The extend output always equals the carry output.
- R5: The zero output is 1 only when `z_i` was 1 and the result byte is 0x00. A nonzero result byte always clears it.
- R6: The negative output equals bit 7 of the corrected result byte.
- R7: Overflow is set when bit 7 of the plain binary sum (destination + source + `x_i`) is 0 and bit 7 of the corrected result is 1. Example: 0x3E + 0x3E with `x_i`=1 gives 0x83 with overflow and negative set.
- R8: Results and flags load on the rising clock edge at which `in_valid` is 1. They change on no other edge, whatever the other inputs do.
- R9: While `rst_n` is 0 at a rising edge, `res_o` and all five flags are cleared to 0.
- R10: Non-decimal digits follow the rule of R2 exactly. Examples: 0xFA + 0x00 with `x_i`=0 gives 0x60 with carry set; 0x0F + 0x0F with `x_i`=0 gives 0x24 with carry clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: capture the result of the current inputs |
| dst_i | input | DATA_W | Destination operand; low byte is added, upper bits pass through |
| src_i | input | DATA_W | Source operand; only the low byte is used |
| x_i | input | 1 | Incoming extend bit, added as carry into the lowest digit |
| z_i | input | 1 | Incoming zero flag, kept only if the result byte is zero |
| res_o | output | DATA_W | Registered result value |
| c_o | output | 1 | Carry out of the decimal add |
| x_o | output | 1 | Extend, copy of carry |
| z_o | output | 1 | Sticky zero flag |
| n_o | output | 1 | Bit 7 of the result byte |
| v_o | output | 1 | Overflow caused by the decimal correction |

## Verification
Every cycle, the assertions check these rules:
- the extend/carry equality;
- pass-through of the upper bits;
- the zero flag's link to a zero result byte and to `z_i`;
- the negative flag against the result byte;
- holding of the outputs without a strobe;
- clearing under reset.

Some rules are visible only through the bench's chosen operand pairs: the decimal correction itself, the carry decision, the overflow rule, and the handling of non-decimal digits. Each of these pairs has a worked expected byte and expected flags.

// File: rtl/bcd_byte_adder_pkg.sv
// Package: shared widths and the flag bundle for the decimal byte adder.
// Assumes a lane width that is a multiple of four bits.
package bcd_byte_adder_pkg;

    localparam int NIBBLE_W = 4;

    // Flag bundle as held in the output register.
    typedef struct packed {
        logic carry;
        logic ext;
        logic zero;
        logic neg;
        logic ovf;
    } bcd_flags_t;

endpackage

// File: rtl/bcd_digit_add.sv
// One decimal digit position: adds two 4-bit digits and a carry of up to
// two, corrects by six when the sum exceeds nine, and passes the high part
// on. Assumes the caller chains the carry from the digit below.
module bcd_digit_add
    import bcd_byte_adder_pkg::*;
(
    input  logic [NIBBLE_W-1:0] a_i,
    input  logic [NIBBLE_W-1:0] b_i,
    input  logic [1:0]          cin_i,
    output logic [NIBBLE_W-1:0] sum_o,
    output logic [1:0]          cout_o,
    output logic                adj_o
);

    localparam int SUM_W = NIBBLE_W + 2;

    logic [SUM_W-1:0] raw;
    logic [SUM_W-1:0] fixed_sum;

    // Binary digit sum, correction decision and corrected value.
    always_comb begin
        raw       = {2'b00, a_i} + {2'b00, b_i} + {{(SUM_W-2){1'b0}}, cin_i};
        adj_o     = (raw > SUM_W'(9));
        fixed_sum = raw + (adj_o ? SUM_W'(6) : SUM_W'(0));
        sum_o     = fixed_sum[NIBBLE_W-1:0];
        cout_o    = fixed_sum[SUM_W-1:NIBBLE_W];
    end

endmodule

// File: rtl/bcd_lane_add.sv
// A full lane of decimal digits built from a chain of digit adders. Also
// gives the plain binary sum MSB, which the overflow rule needs.
// Assumes LANE_W is a multiple of four.
module bcd_lane_add
    import bcd_byte_adder_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  logic              x_i,
    output logic [LANE_W-1:0] sum_o,
    output logic              carry_o,
    output logic              raw_msb_o
);

    localparam int DIGITS = LANE_W / NIBBLE_W;

    logic [1:0]        chain [DIGITS+1];
    logic [DIGITS-1:0] adj;
    logic [LANE_W:0]   bin_sum;

    assign chain[0] = {1'b0, x_i};

    // One digit adder per digit position, carry rippling upward.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_add u_digit (
            .a_i    (a_i[g*NIBBLE_W +: NIBBLE_W]),
            .b_i    (b_i[g*NIBBLE_W +: NIBBLE_W]),
            .cin_i  (chain[g]),
            .sum_o  (sum_o[g*NIBBLE_W +: NIBBLE_W]),
            .cout_o (chain[g+1]),
            .adj_o  (adj[g])
        );
    end

    // The top digit's correction decides the decimal carry.
    assign carry_o = adj[DIGITS-1];

    // Uncorrected binary sum, used only for its MSB.
    always_comb begin
        bin_sum   = {1'b0, a_i} + {1'b0, b_i} + {{LANE_W{1'b0}}, x_i};
        raw_msb_o = bin_sum[LANE_W-1];
    end

endmodule

// File: rtl/bcd_flag_gen.sv
// Next-flag logic: sticky zero, sign, overflow from the correction step,
// and extend tied to carry. Assumes the lane result is already corrected.
module bcd_flag_gen
    import bcd_byte_adder_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] sum_i,
    input  logic              carry_i,
    input  logic              raw_msb_i,
    input  logic              z_i,
    output bcd_flags_t        flags_o
);

    // Build the flag bundle from the lane result.
    always_comb begin
        flags_o.carry = carry_i;
        flags_o.ext   = carry_i;
        flags_o.zero  = z_i & (sum_i == '0);
        flags_o.neg   = sum_i[LANE_W-1];
        flags_o.ovf   = ~raw_msb_i & sum_i[LANE_W-1];
    end

endmodule

// File: rtl/bcd_byte_adder.sv
// Top: decimal add of the low lanes of two register values with extend.
// The result and flags are registered on in_valid; upper destination bits
// pass through. Assumes DATA_W > LANE_W.
module bcd_byte_adder
    import bcd_byte_adder_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              x_i,
    input  logic              z_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              x_o,
    output logic              z_o,
    output logic              n_o,
    output logic              v_o
);

    logic [LANE_W-1:0] lane_sum;
    logic              lane_carry;
    logic              lane_raw_msb;
    bcd_flags_t        flags_next;
    bcd_flags_t        flags_q;
    logic [DATA_W-1:0] res_q;

    bcd_lane_add #(.LANE_W(LANE_W)) u_lane (
        .a_i       (dst_i[LANE_W-1:0]),
        .b_i       (src_i[LANE_W-1:0]),
        .x_i       (x_i),
        .sum_o     (lane_sum),
        .carry_o   (lane_carry),
        .raw_msb_o (lane_raw_msb)
    );

    bcd_flag_gen #(.LANE_W(LANE_W)) u_flags (
        .sum_i     (lane_sum),
        .carry_i   (lane_carry),
        .raw_msb_i (lane_raw_msb),
        .z_i       (z_i),
        .flags_o   (flags_next)
    );

    // Output register: clear on reset, load on strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (in_valid) begin
            res_q   <= {dst_i[DATA_W-1:LANE_W], lane_sum};
            flags_q <= flags_next;
        end
    end

    assign res_o = res_q;
    assign c_o   = flags_q.carry;
    assign x_o   = flags_q.ext;
    assign z_o   = flags_q.zero;
    assign n_o   = flags_q.neg;
    assign v_o   = flags_q.ovf;

endmodule

// File: rtl/bcd_byte_adder_chk.sv
// Checker for the decimal byte adder, bound to every instance of the top.
// Watches ports only.
module bcd_byte_adder_chk #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] dst_i,
    input logic              z_i,
    input logic [DATA_W-1:0] res_o,
    input logic              c_o,
    input logic              x_o,
    input logic              z_o,
    input logic              n_o,
    input logic              v_o
);

    AST_EXT_IS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (x_o == c_o)); // R4

    AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |->
        (res_o[DATA_W-1:LANE_W] == $past(dst_i[DATA_W-1:LANE_W]))); // R1

    AST_ZERO_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(z_i)) |-> !z_o); // R5

    AST_ZERO_MEANS_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (!z_o || (res_o[LANE_W-1:0] == '0))); // R5

    AST_NEG_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (n_o == res_o[LANE_W-1])); // R6

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
        ($stable(res_o) && $stable({c_o, x_o, z_o, n_o, v_o}))); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && {c_o, x_o, z_o, n_o, v_o} == 5'b0)); // R9

endmodule

bind bcd_byte_adder bcd_byte_adder_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .dst_i    (dst_i),
    .z_i      (z_i),
    .res_o    (res_o),
    .c_o      (c_o),
    .x_o      (x_o),
    .z_o      (z_o),
    .n_o      (n_o),
    .v_o      (v_o)
);

// File: tb/bcd_byte_adder_bench.sv
module bcd_byte_adder_bench;

    localparam int DATA_W = 32;
    localparam int NVEC   = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] dst_i = '0;
    logic [DATA_W-1:0] src_i = '0;
    logic              x_i = 1'b0;
    logic              z_i = 1'b0;
    logic [DATA_W-1:0] res_o;
    logic              c_o, x_o, z_o, n_o, v_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bcd_byte_adder #(.DATA_W(DATA_W), .LANE_W(8)) u_bcd_byte_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .dst_i(dst_i), .src_i(src_i), .x_i(x_i), .z_i(z_i),
        .res_o(res_o), .c_o(c_o), .x_o(x_o), .z_o(z_o), .n_o(n_o), .v_o(v_o)
    );

    // {dst, src, x, z, result, c, z, n, v}
    localparam logic [29:0] VEC [NVEC] = '{
        {8'h7A, 8'h78, 1'b0, 1'b0, 8'h58, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h45, 8'h54, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h45, 8'h54, 1'b0, 1'b0, 8'h99, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h3E, 8'h3E, 1'b1, 1'b0, 8'h83, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'hA2, 8'h19, 1'b1, 1'b0, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h45, 8'h54, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h12, 8'h34, 1'b0, 1'b1, 8'h46, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h99, 8'h99, 1'b1, 1'b0, 8'h99, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'hFA, 8'h00, 1'b0, 1'b0, 8'h60, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h09, 8'h00, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h50, 8'h50, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h0F, 8'h0F, 1'b0, 1'b0, 8'h24, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h40, 8'h39, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] s,
                          input logic x, input logic z);
        @(negedge clk);
        dst_i = d; src_i = s; x_i = x; z_i = z; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset result", res_o, '0);
        check("R9 reset flags", {27'd0, c_o, x_o, z_o, n_o, v_o}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [29:0] v;
            logic [DATA_W-1:0] d, s;
            v = VEC[i];
            d = {24'h123456 + 24'(i), v[29:22]};
            s = {24'hF745FF ^ 24'(i), v[21:14]};
            strobe(d, s, v[13], v[12]);
            // R2 R3 R10 result byte, R1 upper bits kept from destination
            check("R2/R10 result byte", {24'd0, res_o[7:0]}, {24'd0, v[11:4]});
            check("R1 upper bits", {8'd0, res_o[31:8]}, {8'd0, d[31:8]});
            check("R3 carry", {31'd0, c_o}, {31'd0, v[3]});
            check("R4 extend", {31'd0, x_o}, {31'd0, v[3]});
            check("R5 zero", {31'd0, z_o}, {31'd0, v[2]});
            check("R6 negative", {31'd0, n_o}, {31'd0, v[1]});
            check("R7 overflow", {31'd0, v_o}, {31'd0, v[0]});
        end

        // R8: inputs change without a strobe; outputs keep the last result (0x80).
        @(negedge clk);
        dst_i = 32'hDEADBE45; src_i = 32'h00000054; x_i = 1'b1; z_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 hold result", res_o, {24'h123456 + 24'd13, 8'h80});
        check("R8 hold flags", {27'd0, c_o, x_o, z_o, n_o, v_o}, 32'b00010 | 32'b00001);

        // R5: a zero chain with sticky zero, then a nonzero byte clears it.
        strobe(32'hAAAAAA00, 32'h00000000, 1'b0, 1'b1);
        check("R5 zero stays", {31'd0, z_o}, 32'd1);
        strobe(32'hAAAAAA01, 32'h00000000, 1'b0, 1'b1);
        check("R5 nonzero clears", {31'd0, z_o}, 32'd0);

        // R9: reset in mid-run clears everything.
        strobe(32'h000000FA, 32'h00000000, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset result", res_o, '0);
        check("R9 mid reset flags", {27'd0, c_o, x_o, z_o, n_o, v_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule